// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Add/Multiply Unit

This block takes two signed two's-complement fixed-point operands. Each operand comes with its own count of fractional bits, so the binary points of the two operands need not line up. A one-bit operation select picks addition or multiplication. The result appears on a register one clock after the inputs are presented, together with the fractional-bit count that says where its binary point sits.

For addition, the unit moves the operand with fewer fractional bits to the left until both operands share the larger count. The shift is done in a field wide enough that no bit is lost, so a shifted operand may exceed the 8-bit range for a moment without harm. Only the final sum is checked against the signed 8-bit range. For multiplication, the unit returns the full 16-bit product. Its fractional count is the sum of the two operand counts.

Every fractional count from 0 (plain integer) to 7 (pure fraction) goes through the same datapath. Operands are widened by sign extension.

Top module: `fxp_mixed_alu`

## Requirements
- R1: While `rst_n` is low, `res_data`, `res_q` and `res_ovf` are all zero.
- R2: A result appears on the outputs at the first rising clock edge after its inputs are applied. Before that edge, the outputs keep the previous result.
- R3: When `op_mul` is 0 (add), `res_q` equals the larger of `a_q` and `b_q`.
- R4: When `op_mul` is 0, the sum is formed exactly. Each operand is first scaled by 2^(res_q − own q). The low 8 bits of that sum go to `res_data[7:0]`, and `res_data[15:8]` are copies of bit 7.
- R5: When `op_mul` is 0, `res_ovf` is 1 exactly when the exact aligned sum lies outside −128..127. An operand that exceeds 8 bits only after alignment does not set the flag if the final sum fits.
- R6: When `op_mul` is 0 and `a_q` equals `b_q`, no shift takes place. `res_data[7:0]` is the 8-bit wrapped sum of the raw operands.
- R7: When `op_mul` is 1, `res_data` is the exact 16-bit signed product of the two operands, and `res_q` equals `a_q + b_q` (0..14).
- R8: When `op_mul` is 1, `res_ovf` is 0.
- R9: The extreme formats and values are handled exactly. Examples: q=0 with q=7, and the most negative value times itself (0x80·0x80 with q=7 each gives 0x4000, q=14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_data | input | 8 | Operand A, two's complement |
| a_q | input | 3 | Fractional-bit count of A |
| b_data | input | 8 | Operand B, two's complement |
| b_q | input | 3 | Fractional-bit count of B |
| op_mul | input | 1 | 0 = add, 1 = multiply |
| res_data | output | 16 | Registered result |
| res_q | output | 4 | Fractional-bit count of the result |
| res_ovf | output | 1 | Add result did not fit in 8 bits |

## Verification
In the add path, alignment and the range check can act in the same cycle. A shift can push an operand beyond 8 bits while the sum comes back into range, or the shift and the sum can both leave the range together. Directed cases provoke both situations: one pairs 64 at q=0 with −128 at q=1, and another pairs large same-sign values at q=0 and q=7. Random operands and formats then mix the two conditions further. Each cycle, the flag and the wrapped value are judged against an integer model that scales both operands to the common q and tests the exact sum.

// File: rtl/fxp_alu_pkg.sv
package fxp_alu_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} fxp_op_e;

  // larger of two fractional counts
  function automatic logic [7:0] q_max(input logic [7:0] x, input logic [7:0] y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/fxp_align.sv
module fxp_align #(
  parameter int W  = 8,
  parameter int QW = 3,
  parameter int AW = W + (1 << QW) - 1
) (
  input  logic [W-1:0]  a,
  input  logic [QW-1:0] aq,
  input  logic [W-1:0]  b,
  input  logic [QW-1:0] bq,
  output logic [AW-1:0] a_al,
  output logic [AW-1:0] b_al,
  output logic [QW-1:0] q_big
);
  import fxp_alu_pkg::*;
  logic [AW-1:0] a_ext, b_ext;
  logic [7:0]    qm8;

  assign a_ext = {{(AW-W){a[W-1]}}, a};
  assign b_ext = {{(AW-W){b[W-1]}}, b};
  assign qm8   = q_max(8'(aq), 8'(bq));
  assign q_big = qm8[QW-1:0];
  // wide field: a left shift never drops a significant bit
  assign a_al  = a_ext << (q_big - aq);
  assign b_al  = b_ext << (q_big - bq);
endmodule

// File: rtl/fxp_add.sv
module fxp_add #(
  parameter int W  = 8,
  parameter int AW = 15
) (
  input  logic [AW-1:0] a_al,
  input  logic [AW-1:0] b_al,
  output logic [W-1:0]  sum,
  output logic          ovf
);
  logic [AW:0] wide;
  logic [AW-W+1:0] top_bits;

  assign wide     = {a_al[AW-1], a_al} + {b_al[AW-1], b_al};
  assign top_bits = wide[AW:W-1];
  assign sum      = wide[W-1:0];
  assign ovf      = !((&top_bits) || !(|top_bits));
endmodule

// File: rtl/fxp_mul.sv
module fxp_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] ax, bx;
  assign ax   = {{W{a[W-1]}}, a};
  assign bx   = {{W{b[W-1]}}, b};
  assign prod = ax * bx;
endmodule

// File: rtl/fxp_mixed_alu.sv
module fxp_mixed_alu #(
  parameter int W  = 8,
  parameter int QW = 3,
  localparam int AW  = W + (1 << QW) - 1,
  localparam int RW  = 2 * W,
  localparam int RQW = QW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a_data,
  input  logic [QW-1:0]  a_q,
  input  logic [W-1:0]   b_data,
  input  logic [QW-1:0]  b_q,
  input  logic           op_mul,
  output logic [RW-1:0]  res_data,
  output logic [RQW-1:0] res_q,
  output logic           res_ovf
);
  import fxp_alu_pkg::*;

  logic [AW-1:0] a_al, b_al;
  logic [QW-1:0] q_big;
  logic [W-1:0]  add_sum;
  logic          add_ovf;
  logic [RW-1:0] mul_prod;
  fxp_op_e       op;

  // named internal events for assertions
  logic [RW-1:0]  nxt_data;
  logic [RQW-1:0] nxt_q;
  logic           nxt_ovf;
  logic           mul_r;
  logic           primed;

  assign op = fxp_op_e'(op_mul);

  fxp_align #(.W(W), .QW(QW), .AW(AW)) u_align (
    .a(a_data), .aq(a_q), .b(b_data), .bq(b_q),
    .a_al(a_al), .b_al(b_al), .q_big(q_big)
  );

  fxp_add #(.W(W), .AW(AW)) u_add (
    .a_al(a_al), .b_al(b_al), .sum(add_sum), .ovf(add_ovf)
  );

  fxp_mul #(.W(W)) u_mul (
    .a(a_data), .b(b_data), .prod(mul_prod)
  );

  always_comb begin
    if (op == OP_MUL) begin
      nxt_data = mul_prod;
      nxt_q    = RQW'(a_q) + RQW'(b_q);
      nxt_ovf  = 1'b0;
    end else begin
      nxt_data = {{(RW-W){add_sum[W-1]}}, add_sum};
      nxt_q    = RQW'(q_big);
      nxt_ovf  = add_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data <= '0;
      res_q    <= '0;
      res_ovf  <= 1'b0;
      mul_r    <= 1'b0;
      primed   <= 1'b0;
    end else begin
      res_data <= nxt_data;
      res_q    <= nxt_q;
      res_ovf  <= nxt_ovf;
      mul_r    <= op_mul;
      primed   <= 1'b1;
    end
  end

  AST_MUL_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    mul_r |-> !res_ovf); // R8

  AST_ADD_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_r |-> (res_data[RW-1:W] == {(RW-W){res_data[W-1]}})); // R4

  AST_ADD_QMAX: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(op_mul)) |->
      (res_q == RQW'(($past(a_q) > $past(b_q)) ? $past(a_q) : $past(b_q)))); // R3

  AST_MUL_QSUM: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_mul)) |->
      (res_q == RQW'($past(a_q)) + RQW'($past(b_q)))); // R7

  AST_ADD_SAME_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(op_mul) && ($past(a_q) == $past(b_q))) |->
      (res_data[W-1:0] == W'($past(a_data) + $past(b_data)))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !$past(rst_n) |-> (res_data == '0 && res_q == '0 && !res_ovf)); // R1
endmodule

// File: tb/fxp_mixed_alu_test.sv
module fxp_mixed_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_data = '0, b_data = '0;
  logic [2:0]  a_q = '0, b_q = '0;
  logic        op_mul = 1'b0;
  logic [15:0] res_data;
  logic [3:0]  res_q;
  logic        res_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fxp_mixed_alu uut (
    .clk(clk), .rst_n(rst_n), .a_data(a_data), .a_q(a_q),
    .b_data(b_data), .b_q(b_q), .op_mul(op_mul),
    .res_data(res_data), .res_q(res_q), .res_ovf(res_ovf)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference: exact scaled-integer arithmetic
  task automatic run(input logic [7:0] a, input int aq, input logic [7:0] b,
                     input int bq, input bit mul, input string req);
    int av, bv, qm, s, e_q, e_ovf;
    logic [15:0] e_data, prev_data;
    av = int'($signed(a));
    bv = int'($signed(b));
    if (mul) begin
      s = av * bv; e_q = aq + bq; e_ovf = 0;
      e_data = 16'(s);
    end else begin
      qm = (aq > bq) ? aq : bq;
      s = (av * (1 << (qm - aq))) + (bv * (1 << (qm - bq)));
      e_q = qm;
      e_ovf = (s > 127 || s < -128) ? 1 : 0;
      e_data = 16'(int'($signed(8'(s))));
    end
    @(negedge clk);
    prev_data = res_data;
    a_data = a; a_q = 3'(aq); b_data = b; b_q = 3'(bq); op_mul = mul;
    #1;
    check("R2", "hold before edge", longint'(res_data), longint'(prev_data));
    @(negedge clk);
    check(req, "data", longint'(res_data), longint'(e_data));
    check(req, "q", longint'(res_q), longint'(e_q));
    check(req, "ovf", longint'(res_ovf), longint'(e_ovf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "data in reset", longint'(res_data), 0);
    check("R1", "q in reset", longint'(res_q), 0);
    check("R1", "ovf in reset", longint'(res_ovf), 0);
    rst_n = 1'b1;
    // worked examples: -19/8 (q3) with 97/16 (q4)
    run(8'hED, 3, 8'h61, 4, 1'b0, "R4");   // 59 at q4
    run(8'hED, 3, 8'h61, 4, 1'b1, "R7");   // -1843 at q7
    // temporary excursion: 64(q0)<<1 = 128, plus -128 -> 0
    run(8'h40, 0, 8'h80, 1, 1'b0, "R5");
    run(8'h64, 2, 8'h64, 2, 1'b0, "R5");   // 200 -> overflow
    run(8'h7F, 0, 8'h7F, 7, 1'b0, "R5");   // shift and sum both out
    run(8'h80, 0, 8'h00, 7, 1'b0, "R9");   // q0 vs q7 out of range
    run(8'h05, 3, 8'hFD, 3, 1'b0, "R6");
    run(8'h02, 1, 8'h03, 5, 1'b0, "R3");
    run(8'h80, 7, 8'h80, 7, 1'b1, "R9");   // 0x4000, q14
    run(8'h7F, 7, 8'h80, 0, 1'b1, "R8");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra, rb;
      bit rm;
      ra = 8'($urandom);
      rb = 8'($urandom);
      rm = 1'($urandom);
      run(ra, int'($urandom_range(0, 7)), rb, int'($urandom_range(0, 7)), rm,
          rm ? "R7" : "R4");
    end
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "data after reset", longint'(res_data), 0);
    check("R1", "q after reset", longint'(res_q), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule